// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the combinational hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers the execute and decode instructions read, the destination registers and write flags of the later stages, whether the execute instruction is a load, and whether execute has resolved a taken branch or jump. From these it produces the operand bypass selects for the execute-stage ALU and the hold and bubble controls for the front-end pipeline registers.

Both ALU operands are bypassed independently, from the memory-stage result or the writeback-stage result. A load whose destination the very next instruction reads costs one hold cycle, after which the normal bypass supplies the value. Because control transfers are decided in execute, a taken redirect squashes the two younger instructions in the fetch and decode slots. A rotate-type ALU instruction needs nothing extra here and uses the same bypass paths as any other ALU result.

All outputs are pure functions of the current inputs, so the datapath uses them in the same cycle the inputs are presented.

Top module: `hazard_ctrl`

## Requirements
- R1: When an execute source register is nonzero, equals the memory-stage destination, and the memory-stage write flag is 1, that operand's select is 2'b10.
- R2: When an execute source register is nonzero, equals the writeback-stage destination with its write flag 1, and no enabled memory-stage match exists, that operand's select is 2'b01.
- R3: When the memory and writeback stages both match an operand with write flags set, the select is 2'b10, since the memory stage holds the newer value.
- R4: Register 0 never triggers a bypass or a hold, and a stage whose write flag is 0 never triggers one; the select then is 2'b00 (register-file value).
- R5: When the execute instruction is a load with its write flag set and a nonzero destination equal to either decode source register, and no redirect is present, hold_pc and hold_fd are 1, flush_de is 1 and flush_fd is 0.
- R6: A non-load execute instruction whose destination matches a decode source causes no hold and no flush.
- R7: A taken redirect from execute sets flush_fd and flush_de to 1 with both holds 0.
- R8: When a load-use hold and a redirect coincide, the redirect wins: both flushes are 1 and both holds are 0.
- R9: The two operand selects are decided independently, so operand A and operand B may take different sources in the same cycle.
- R10: The operand selects do not depend on the hold or flush conditions, and all outputs settle in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | 5 | First source register of the decode instruction |
| dec_rt | input | 5 | Second source register of the decode instruction |
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register of the execute instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| ex_redirect | input | 1 | Execute resolved a taken branch or jump |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 memory, 01 writeback |
| fwd_b | output | 2 | Operand B source, same encoding |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_fd | output | 1 | Keep the fetch/decode register unchanged |
| flush_fd | output | 1 | Clear the fetch/decode register to a bubble |
| flush_de | output | 1 | Clear the decode/execute register to a bubble |

## Verification
Every output is combinational, so each result is due in the very cycle its inputs are applied, with zero register delay. The driver applies one input vector just after a rising edge and queues the expected outputs; the monitor pops and compares at the following falling edge, half a period later, when the inputs are stable and no edge is pending. Each vector stays applied for a full cycle, so each comparison sees exactly one stimulus.

// File: rtl/hazard_pkg.sv
// Package: shared encodings for the hazard controller.
// Assumes the datapath decodes the bypass select with exactly these codes.
package hazard_pkg;

    // Operand source select for the execute-stage ALU inputs.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } src_sel_e;

endpackage

// File: rtl/hazard_bypass_sel.sv
// Module: hazard_bypass_sel
// Picks the source of one execute-stage ALU operand. A nonzero source
// register matching an enabled producer is bypassed; the memory stage
// outranks writeback because it carries the younger result.
// Assumes register 0 reads as constant zero.
module hazard_bypass_sel
    import hazard_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic              wb_wr_en,
    output src_sel_e          sel
);

    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Match detection against each producer stage.
    always_comb begin
        src_live = (src != ZERO_REG);
        hit_mem  = src_live && mem_wr_en && (mem_dst == src);
        hit_wb   = src_live && wb_wr_en  && (wb_dst  == src);
    end

    // Priority choice: memory first, then writeback, else register file.
    always_comb begin
        if (hit_mem)
            sel = SRC_MEM;
        else if (hit_wb)
            sel = SRC_WB;
        else
            sel = SRC_REGFILE;
    end

    // Checks on the chosen select against the raw inputs.
    always_comb begin
        if (!$isunknown({src, mem_dst, mem_wr_en, wb_dst, wb_wr_en})) begin
            p_zero_reg_r4: assert (src != ZERO_REG || sel == SRC_REGFILE)
                else $error("register 0 bypassed");
            p_mem_wins_r3: assert (!(mem_wr_en && mem_dst == src && src != ZERO_REG)
                                   || sel == SRC_MEM)
                else $error("memory match not selected");
            p_legal_code_r1: assert (sel != 2'b11)
                else $error("illegal select code");
            p_wb_enabled_r2: assert (sel != SRC_WB || wb_wr_en)
                else $error("writeback bypass without write flag");
        end
    end

endmodule

// File: rtl/hazard_load_use.sv
// Module: hazard_load_use
// Flags a load in execute whose destination is read by the decode
// instruction. Assumes the load result is first bypassable from memory.
module hazard_load_use #(
    parameter int ADDR_W = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC*ADDR_W-1:0] dec_srcs,
    input  logic [ADDR_W-1:0]      ex_dst,
    input  logic                   ex_wr_en,
    input  logic                   ex_load,
    output logic                   conflict
);

    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_hit;
    logic            producer_live;

    // Load producer qualifies only when it really writes a nonzero register.
    always_comb producer_live = ex_load && ex_wr_en && (ex_dst != ZERO_REG);

    // One comparator per decode source register.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb src_hit[i] = producer_live
                                 && (dec_srcs[i*ADDR_W +: ADDR_W] == ex_dst);
    end

    // Any hit demands a one-cycle hold.
    always_comb conflict = |src_hit;

    // Conflict only with a live load producer.
    always_comb begin
        if (!$isunknown({dec_srcs, ex_dst, ex_wr_en, ex_load})) begin
            p_load_only_r6: assert (!conflict || (ex_load && ex_wr_en))
                else $error("hold raised for non-load producer");
            p_zero_dst_r4: assert (!conflict || ex_dst != ZERO_REG)
                else $error("hold raised for register 0");
        end
    end

endmodule

// File: rtl/hazard_ctrl.sv
// Module: hazard_ctrl (top)
// Combinational hazard controller for a five-stage in-order pipeline.
// Produces both ALU operand bypass selects, front-end holds and bubble
// flushes. Assumes branches and jumps resolve in execute.
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SEL_W  = 2
) (
    input  logic [ADDR_W-1:0] dec_rs,
    input  logic [ADDR_W-1:0] dec_rt,
    input  logic [ADDR_W-1:0] ex_rs,
    input  logic [ADDR_W-1:0] ex_rt,
    input  logic [ADDR_W-1:0] ex_dst,
    input  logic              ex_wr_en,
    input  logic              ex_load,
    input  logic [ADDR_W-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic              wb_wr_en,
    input  logic              ex_redirect,
    output logic [SEL_W-1:0]  fwd_a,
    output logic [SEL_W-1:0]  fwd_b,
    output logic              hold_pc,
    output logic              hold_fd,
    output logic              flush_fd,
    output logic              flush_de
);

    localparam int NOPER = 2;

    logic [NOPER*ADDR_W-1:0] ex_srcs;
    src_sel_e                oper_sel [NOPER];
    logic                    lu_conflict;
    logic                    lu_hold;

    // Gather execute source registers for the per-operand selectors.
    always_comb ex_srcs = {ex_rt, ex_rs};

    // One bypass selector per ALU operand.
    for (genvar k = 0; k < NOPER; k++) begin : g_oper
        hazard_bypass_sel #(.ADDR_W(ADDR_W)) u_sel (
            .src       (ex_srcs[k*ADDR_W +: ADDR_W]),
            .mem_dst   (mem_dst),
            .mem_wr_en (mem_wr_en),
            .wb_dst    (wb_dst),
            .wb_wr_en  (wb_wr_en),
            .sel       (oper_sel[k])
        );
    end

    // Drive select outputs from the operand selectors.
    always_comb begin
        fwd_a = SEL_W'(oper_sel[0]);
        fwd_b = SEL_W'(oper_sel[1]);
    end

    // Load-use detection against both decode sources.
    hazard_load_use #(.ADDR_W(ADDR_W), .NSRC(NOPER)) u_lu (
        .dec_srcs (({dec_rt, dec_rs})),
        .ex_dst   (ex_dst),
        .ex_wr_en (ex_wr_en),
        .ex_load  (ex_load),
        .conflict (lu_conflict)
    );

    // A redirect squashes the younger instructions, so it cancels the hold.
    always_comb lu_hold = lu_conflict && !ex_redirect;

    // Front-end control: hold PC and F/D, bubble D/E; redirect flushes both.
    always_comb begin
        hold_pc  = lu_hold;
        hold_fd  = lu_hold;
        flush_fd = ex_redirect;
        flush_de = lu_hold || ex_redirect;
    end

    // Cross-checks between the hold, flush and redirect controls.
    always_comb begin
        if (!$isunknown({dec_rs, dec_rt, ex_dst, ex_wr_en, ex_load, ex_redirect})) begin
            p_hold_pair_r5: assert (hold_pc == hold_fd)
                else $error("PC and F/D holds disagree");
            p_hold_bubble_r5: assert (!hold_pc || flush_de)
                else $error("hold without D/E bubble");
            p_redirect_wins_r8: assert (!ex_redirect || (!hold_pc && flush_fd && flush_de))
                else $error("redirect did not override hold");
            p_fd_flush_cause_r7: assert (!flush_fd || ex_redirect)
                else $error("F/D flushed without redirect");
        end
    end

endmodule

// File: tb/hazard_ctrl_bench.sv
// Bench for hazard_ctrl: driver queues expected outputs, monitor compares.
module hazard_ctrl_bench;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] dec_rs = '0, dec_rt = '0, ex_rs = '0, ex_rt = '0, ex_dst = '0;
    logic       ex_wr_en = 1'b0, ex_load = 1'b0;
    logic [4:0] mem_dst = '0, wb_dst = '0;
    logic       mem_wr_en = 1'b0, wb_wr_en = 1'b0, ex_redirect = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       hold_pc, hold_fd, flush_fd, flush_de;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    hazard_ctrl u_hazard_ctrl (
        .dec_rs(dec_rs), .dec_rt(dec_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_dst(ex_dst), .ex_wr_en(ex_wr_en), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .ex_redirect(ex_redirect),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_pc(hold_pc), .hold_fd(hold_fd),
        .flush_fd(flush_fd), .flush_de(flush_de)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Driver: apply a vector after a rising edge and queue its expectation.
    // exp = {fwd_a, fwd_b, hold_pc, hold_fd, flush_fd, flush_de}
    task automatic drive(input logic [4:0] drs, drt, ers, ert, exd,
                         input logic ewe, eld,
                         input logic [4:0] md, input logic mwe,
                         input logic [4:0] wd, input logic wwe,
                         input logic redir, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        dec_rs = drs; dec_rt = drt; ex_rs = ers; ex_rt = ert; ex_dst = exd;
        ex_wr_en = ewe; ex_load = eld; mem_dst = md; mem_wr_en = mwe;
        wb_dst = wd; wb_wr_en = wwe; ex_redirect = redir;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, results are same-cycle.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = {fwd_a, fwd_b, hold_pc, hold_fd, flush_fd, flush_de};
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual=%08b expected=%08b", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        //      drs drt ers ert exd ewe eld md mwe wd wwe rd  exp
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'b00_00_0000, "R4 idle state");
        drive(0, 0, 3, 4, 0, 0, 0, 3, 1, 0, 0, 0, 8'b10_00_0000, "R1 mem bypass A");
        drive(0, 0, 1, 7, 0, 0, 0, 2, 1, 7, 1, 0, 8'b00_01_0000, "R2 wb bypass B");
        drive(0, 0, 5, 5, 0, 0, 0, 5, 1, 5, 1, 0, 8'b10_10_0000, "R3 mem beats wb");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 8'b00_00_0000, "R4 reg0 no bypass");
        drive(0, 0, 6, 6, 0, 0, 0, 6, 0, 6, 0, 0, 8'b00_00_0000, "R4 write flags low");
        drive(0, 0, 6, 2, 0, 0, 0, 6, 0, 6, 1, 0, 8'b01_00_0000, "R2 disabled mem falls to wb");
        drive(0, 0, 8, 9, 0, 0, 0, 8, 1, 9, 1, 0, 8'b10_01_0000, "R9 independent operands");
        drive(4, 1, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 8'b00_00_1101, "R5 load-use on rs");
        drive(2, 4, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 8'b00_00_1101, "R5 load-use on rt");
        drive(2, 3, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 8'b00_00_0000, "R5 load without match");
        drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 8'b00_00_0000, "R4 load to reg0");
        drive(4, 0, 0, 0, 4, 0, 1, 0, 0, 0, 0, 0, 8'b00_00_0000, "R4 load write flag low");
        drive(4, 4, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 8'b00_00_0000, "R6 alu producer no hold");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'b00_00_0011, "R7 redirect flush");
        drive(4, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 1, 8'b00_00_0011, "R8 redirect over load-use");
        drive(4, 0, 3, 9, 4, 1, 1, 3, 1, 9, 1, 0, 8'b10_01_1101, "R10 bypass with hold");
        drive(0, 0, 3, 9, 0, 0, 0, 3, 1, 9, 1, 1, 8'b10_01_0011, "R10 bypass with flush");
        drive(0, 0, 31, 31, 0, 0, 0, 30, 1, 31, 1, 0, 8'b01_01_0000, "R2 top register wb");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule